// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer with Auto-Refresh

This block is the control state machine of a DDR SDRAM controller. A client hands it one of four two-bit commands: no-op, read, write or refresh. With the command comes a single word that packs bank, row and column. The sequencer turns each request into the right series of memory commands on the chip-select, RAS, CAS and WE lines, the bank address and the address bus. Between commands it inserts no-op cycles, so that the device's minimum spacing is met for each command type. The data path, strobes and clocking sit outside the block. It gives only a ready handshake and a read-data-valid strobe timed to the CAS latency.

After reset the sequencer drives no-op while a power-up counter runs to its limit. It then walks through the device initialization and becomes ready. Reads and writes each open the row with an activate command, followed by a column command that requests auto-precharge. A write is followed by a recovery interval of no-op cycles that covers both write recovery and precharge time. A refresh timer tracks the cycles since the last refresh. When the deadline comes within a guard window, the idle state issues a refresh ahead of any new user work.

States and transitions:

- ST_PWRUP goes to ST_INIT_PRE1 when the counter reaches its limit.
- The initialization chain runs through ST_INIT_PRE1, ST_INIT_EMR, ST_INIT_MR_RST, ST_INIT_PRE2, ST_INIT_REF1, ST_INIT_REF2 and ST_INIT_MR, and ends in ST_IDLE.
- ST_IDLE goes to ST_REFRESH when a refresh is due or a user refresh is accepted. It goes to ST_ACT when a user read or write is accepted.
- ST_ACT goes to ST_READ or ST_WRITE.
- ST_READ goes back to ST_IDLE.
- ST_WRITE goes to ST_WR_RECOV and then to ST_IDLE.
- ST_REFRESH goes back to ST_IDLE.
- Every command state whose spacing count is non-zero passes through ST_WAIT. That state holds no-op for the count, then moves on to the next state of the chain.

Top module: `sdram_cmd_seq`

## Requirements
- R1: During reset, and for INIT_LIMIT+1 cycles after reset is released, the command lines {cs_n,ras_n,cas_n,we_n} read 1111 (no-op), usr_ready is low and rd_valid is low.
- R2: Initialization issues these commands in order, then raises usr_ready:
  1. precharge-all: bank 00, address bit 10 set, other address bits zero.
  2. extended mode load: bank 01, address 0x002.
  3. mode load with DLL reset: bank 00, address 0x121.
  4. precharge-all.
  5. refresh.
  6. refresh.
  7. mode load with DLL reset cleared: bank 00, address 0x021.
- R3: Command line codes {cs_n,ras_n,cas_n,we_n} are: no-op 1111, mode load 0000, activate 0011, precharge 0010, read 0101, write 0100, refresh 0001. No other code appears.
- R4: After a command, the number of no-op cycles before the next command is fixed per type:
  - mode load: T_MRD-1
  - activate: T_RCD-1
  - precharge: T_RP-1
  - refresh: T_RFC-1
  - read: 0
- R5: A read (usr_cmd 01) accepted while usr_ready is high produces two commands. The first is an activate with bank usr_addr[27:26] and row usr_addr[25:13]. The second is a read with the same bank and column usr_addr[12:0], with address bit 10 forced to 1.
- R6: An accepted write (usr_cmd 10) produces the same activate/column pair, using the write code. It is followed by T_WR+T_RP-1 no-op cycles with usr_ready low.
- R7: An accepted user refresh (usr_cmd 11) issues a refresh command with bank 00 and address 0 in the next cycle.
- R8: usr_ready is high only while the sequencer is idle and no refresh is due. A command offered while usr_ready is low, or a no-op command, has no effect on the command lines.
- R9: When REFRESH_INTERVAL-REFRESH_WINDOW cycles have passed since the last refresh, usr_ready drops in the idle state. A refresh follows in the next cycle. Two refresh commands are never more than REFRESH_INTERVAL cycles apart.
- R10: rd_valid is high exactly CAS_LAT cycles after each cycle in which the read code is driven, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usr_cmd | input | 2 | User command: 00 no-op, 01 read, 10 write, 11 refresh |
| usr_addr | input | 2*ROW_W+BANK_W | Packed bank, row, column |
| usr_ready | output | 1 | High when a user command is taken this cycle |
| rd_valid | output | 1 | Read data valid strobe |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BANK_W | Bank address |
| mem_addr | output | ROW_W | Row, column or mode word |

## Verification
The command lines and usr_ready come straight from the state register, so a wrong state shows at the ports in the same cycle. It appears either as a wrong command code or as ready being high or low at the wrong moment. A wrong spacing count shows one cycle early or late on the next command. A refresh counter that loses count shows as usr_ready failing to drop at the due point, or dropping too early, and later as a gap between refreshes longer than the interval. A fault in the latency pipe shows as rd_valid high in a cycle other than CAS_LAT cycles after a read.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    // command line codes, order {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] LN_NOP  = 4'b1111;
    localparam logic [3:0] LN_MODE = 4'b0000;
    localparam logic [3:0] LN_ACT  = 4'b0011;
    localparam logic [3:0] LN_PRE  = 4'b0010;
    localparam logic [3:0] LN_RD   = 4'b0101;
    localparam logic [3:0] LN_WR   = 4'b0100;
    localparam logic [3:0] LN_REF  = 4'b0001;

    // user command codes
    localparam logic [1:0] UC_NOP = 2'b00;
    localparam logic [1:0] UC_RD  = 2'b01;
    localparam logic [1:0] UC_WR  = 2'b10;
    localparam logic [1:0] UC_REF = 2'b11;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_INIT_PRE1,
        ST_INIT_EMR,
        ST_INIT_MR_RST,
        ST_INIT_PRE2,
        ST_INIT_REF1,
        ST_INIT_REF2,
        ST_INIT_MR,
        ST_IDLE,
        ST_ACT,
        ST_READ,
        ST_WRITE,
        ST_WR_RECOV,
        ST_REFRESH,
        ST_WAIT
    } seq_state_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seq_init_timer.sv
module seq_init_timer #(
    parameter int W     = 15,
    parameter int LIMIT = 32767
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    logic [W-1:0] cnt;

    assign done = (cnt == W'(LIMIT));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R1: the counter never runs past its limit
    p_init_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

endmodule

// File: rtl/seq_gap_timer.sv
module seq_gap_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         last
);
    logic [W-1:0] cnt;

    // the wait state ends on the cycle holding a count of one
    assign last = (cnt <= W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/seq_refresh_timer.sv
module seq_refresh_timer #(
    parameter int INTERVAL = 780,
    parameter int WINDOW   = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic issued,
    output logic due
);
    localparam int CW     = $clog2(INTERVAL + 1);
    localparam int DUE_AT = INTERVAL - WINDOW;

    logic [CW-1:0] cnt;

    assign due = (cnt >= CW'(DUE_AT));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (hold || issued) begin
            cnt <= '0;
        end else if (cnt != CW'(INTERVAL)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R9: a refresh always lands before the interval runs out
    p_no_overdue_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(INTERVAL));

endmodule

// File: rtl/seq_lat_pipe.sv
module seq_lat_pipe #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [DEPTH-1:0] sr;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) sr <= '0;
                else        sr <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) sr <= '0;
                else        sr <= {sr[DEPTH-2:0], din};
            end
        end
    endgenerate

    assign dout = sr[DEPTH-1];

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int ROW_W            = 13,
    parameter int BANK_W           = 2,
    parameter int AP_BIT           = 10,
    parameter int INIT_W           = 15,
    parameter int INIT_LIMIT       = 32767,
    parameter int REFRESH_INTERVAL = 780,
    parameter int REFRESH_WINDOW   = 25,
    parameter int T_RP             = 2,
    parameter int T_RFC            = 8,
    parameter int T_MRD            = 2,
    parameter int T_RCD            = 2,
    parameter int T_WR             = 2,
    parameter int CAS_LAT          = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  usr_cmd,
    input  logic [2*ROW_W+BANK_W-1:0]   usr_addr,
    output logic                        usr_ready,
    output logic                        rd_valid,
    output logic                        mem_cs_n,
    output logic                        mem_ras_n,
    output logic                        mem_cas_n,
    output logic                        mem_we_n,
    output logic [BANK_W-1:0]           mem_ba,
    output logic [ROW_W-1:0]            mem_addr
);
    localparam int UADDR_W = 2 * ROW_W + BANK_W;
    localparam int G_MRD   = T_MRD - 1;
    localparam int G_RCD   = T_RCD - 1;
    localparam int G_RP    = T_RP - 1;
    localparam int G_RFC   = T_RFC - 1;
    localparam int G_WREC  = T_WR + T_RP - 1;
    localparam int G_MAX   = max2(max2(max2(G_MRD, G_RCD), max2(G_RP, G_RFC)), max2(G_WREC, 1));
    localparam int GAP_W   = $clog2(G_MAX + 1);

    // mode word: burst length 2 (code 1), sequential, CAS latency, DLL reset flag
    function automatic logic [ROW_W-1:0] mode_word(input logic dll_rst);
        logic [ROW_W-1:0] w;
        w      = '0;
        w[2:0] = 3'd1;
        w[6:4] = 3'(CAS_LAT);
        w[8]   = dll_rst;
        return w;
    endfunction

    // extended mode word: DLL enabled (bit 0 low), reduced drive (bit 1)
    function automatic logic [ROW_W-1:0] ext_word();
        logic [ROW_W-1:0] w;
        w    = '0;
        w[1] = 1'b1;
        return w;
    endfunction

    localparam logic [ROW_W-1:0]  MR_RST_WORD = mode_word(1'b1);
    localparam logic [ROW_W-1:0]  MR_RUN_WORD = mode_word(1'b0);
    localparam logic [ROW_W-1:0]  EMR_WORD    = ext_word();
    localparam logic [BANK_W-1:0] EMR_BANK    = BANK_W'(1);

    seq_state_t        st_q, st_d, ret_q, ret_d, nxt, hold_st;
    logic              issue;
    logic [GAP_W-1:0]  gap;
    logic              t_last;
    logic              init_done;
    logic              rfsh_due;
    logic              rfsh_issue;
    logic              rd_issue;
    logic              accept;
    logic              is_wr_q;
    logic [UADDR_W-1:0] ua_q;
    logic [3:0]        lines;

    // ---------------------------------------------------------------- helpers
    seq_init_timer #(
        .W     (INIT_W),
        .LIMIT (INIT_LIMIT)
    ) i_init (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (init_done)
    );

    seq_gap_timer #(
        .W (GAP_W)
    ) i_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (issue),
        .val   (gap),
        .last  (t_last)
    );

    seq_refresh_timer #(
        .INTERVAL (REFRESH_INTERVAL),
        .WINDOW   (REFRESH_WINDOW)
    ) i_rfsh (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (st_q == ST_PWRUP),
        .issued (rfsh_issue),
        .due    (rfsh_due)
    );

    seq_lat_pipe #(
        .DEPTH (CAS_LAT)
    ) i_rdpipe (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rd_issue),
        .dout  (rd_valid)
    );

    assign rfsh_issue = (st_q == ST_INIT_REF1) || (st_q == ST_INIT_REF2) || (st_q == ST_REFRESH);
    assign rd_issue   = (st_q == ST_READ);
    assign usr_ready  = (st_q == ST_IDLE) && !rfsh_due;
    assign accept     = usr_ready && (usr_cmd != UC_NOP);

    // ---------------------------------------------------------------- next state
    always_comb begin : next_state
        st_d    = st_q;
        ret_d   = ret_q;
        issue   = 1'b0;
        nxt     = ST_IDLE;
        hold_st = ST_WAIT;
        gap     = '0;
        unique case (st_q)
            ST_PWRUP: begin
                if (init_done) st_d = ST_INIT_PRE1;
            end
            ST_INIT_PRE1: begin
                issue = 1'b1;
                nxt   = ST_INIT_EMR;
                gap   = GAP_W'(G_RP);
            end
            ST_INIT_EMR: begin
                issue = 1'b1;
                nxt   = ST_INIT_MR_RST;
                gap   = GAP_W'(G_MRD);
            end
            ST_INIT_MR_RST: begin
                issue = 1'b1;
                nxt   = ST_INIT_PRE2;
                gap   = GAP_W'(G_MRD);
            end
            ST_INIT_PRE2: begin
                issue = 1'b1;
                nxt   = ST_INIT_REF1;
                gap   = GAP_W'(G_RP);
            end
            ST_INIT_REF1: begin
                issue = 1'b1;
                nxt   = ST_INIT_REF2;
                gap   = GAP_W'(G_RFC);
            end
            ST_INIT_REF2: begin
                issue = 1'b1;
                nxt   = ST_INIT_MR;
                gap   = GAP_W'(G_RFC);
            end
            ST_INIT_MR: begin
                issue = 1'b1;
                nxt   = ST_IDLE;
                gap   = GAP_W'(G_MRD);
            end
            ST_IDLE: begin
                if (rfsh_due) begin
                    st_d = ST_REFRESH;
                end else if (accept) begin
                    st_d = (usr_cmd == UC_REF) ? ST_REFRESH : ST_ACT;
                end
            end
            ST_ACT: begin
                issue = 1'b1;
                nxt   = is_wr_q ? ST_WRITE : ST_READ;
                gap   = GAP_W'(G_RCD);
            end
            ST_READ: begin
                issue = 1'b1;
                nxt   = ST_IDLE;
                gap   = '0;
            end
            ST_WRITE: begin
                issue   = 1'b1;
                nxt     = ST_IDLE;
                hold_st = ST_WR_RECOV;
                gap     = GAP_W'(G_WREC);
            end
            ST_REFRESH: begin
                issue = 1'b1;
                nxt   = ST_IDLE;
                gap   = GAP_W'(G_RFC);
            end
            ST_WAIT, ST_WR_RECOV: begin
                if (t_last) st_d = ret_q;
            end
            default: st_d = ST_PWRUP;
        endcase
        if (issue) begin
            if (gap == '0) begin
                st_d = nxt;
            end else begin
                st_d  = hold_st;
                ret_d = nxt;
            end
        end
    end

    // ---------------------------------------------------------------- state register
    always_ff @(posedge clk) begin : state_reg
        if (!rst_n) begin
            st_q    <= ST_PWRUP;
            ret_q   <= ST_IDLE;
            ua_q    <= '0;
            is_wr_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            ret_q <= ret_d;
            if (accept) begin
                ua_q    <= usr_addr;
                is_wr_q <= (usr_cmd == UC_WR);
            end
        end
    end

    // ---------------------------------------------------------------- outputs
    always_comb begin : drive_lines
        lines    = LN_NOP;
        mem_ba   = '0;
        mem_addr = '0;
        unique case (st_q)
            ST_INIT_PRE1, ST_INIT_PRE2: begin
                lines            = LN_PRE;
                mem_addr[AP_BIT] = 1'b1;
            end
            ST_INIT_EMR: begin
                lines    = LN_MODE;
                mem_ba   = EMR_BANK;
                mem_addr = EMR_WORD;
            end
            ST_INIT_MR_RST: begin
                lines    = LN_MODE;
                mem_addr = MR_RST_WORD;
            end
            ST_INIT_MR: begin
                lines    = LN_MODE;
                mem_addr = MR_RUN_WORD;
            end
            ST_INIT_REF1, ST_INIT_REF2, ST_REFRESH: begin
                lines = LN_REF;
            end
            ST_ACT: begin
                lines    = LN_ACT;
                mem_ba   = ua_q[UADDR_W-1 -: BANK_W];
                mem_addr = ua_q[2*ROW_W-1 : ROW_W];
            end
            ST_READ, ST_WRITE: begin
                lines            = (st_q == ST_READ) ? LN_RD : LN_WR;
                mem_ba           = ua_q[UADDR_W-1 -: BANK_W];
                mem_addr         = ua_q[ROW_W-1:0];
                mem_addr[AP_BIT] = 1'b1;
            end
            default: ;
        endcase
    end

    assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = lines;

    // ---------------------------------------------------------------- assertions
    // R8: ready is only offered while no-op is on the lines
    p_ready_nop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        usr_ready |-> (lines == LN_NOP));

    // R5: every column command asks for auto-precharge
    p_autopre_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((lines == LN_RD) || (lines == LN_WR)) |-> mem_addr[AP_BIT]);

    // R6: a write is followed by recovery with ready low
    p_wr_recov_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lines == LN_WR) |=> ((lines == LN_NOP) && !usr_ready));

    // R4: a refresh is followed by at least one no-op
    p_ref_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((lines == LN_REF) && (T_RFC > 1)) |=> (lines == LN_NOP));

    // R10: read valid follows a read command by the CAS latency
    generate
        if (CAS_LAT == 2) begin : g_rdv_chk
            p_rdv_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
                rd_valid |-> $past(lines == LN_RD, 2));
        end
    endgenerate

endmodule

// File: tb/test_sdram_cmd_seq.sv
module test_sdram_cmd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int INIT_LIM   = 20;
    localparam int RI         = 780;
    localparam int RW         = 25;
    localparam int TRP        = 2;
    localparam int TRFC       = 8;
    localparam int TMRD       = 2;
    localparam int TRCD       = 2;
    localparam int TWR        = 2;
    localparam int CL         = 2;

    localparam logic [3:0] C_NOP = 4'b1111, C_MODE = 4'b0000, C_ACT = 4'b0011,
                           C_PRE = 4'b0010, C_RD = 4'b0101, C_WR = 4'b0100,
                           C_REF = 4'b0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  usr_cmd = 2'b00;
    logic [27:0] usr_addr = '0;
    logic        usr_ready, rd_valid;
    logic        mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
    logic [1:0]  mem_ba;
    logic [12:0] mem_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cmd_seq #(
        .INIT_LIMIT (INIT_LIM), .REFRESH_INTERVAL (RI), .REFRESH_WINDOW (RW),
        .T_RP (TRP), .T_RFC (TRFC), .T_MRD (TMRD), .T_RCD (TRCD),
        .T_WR (TWR), .CAS_LAT (CL)
    ) i_sdram_cmd_seq (
        .clk (clk), .rst_n (rst_n), .usr_cmd (usr_cmd), .usr_addr (usr_addr),
        .usr_ready (usr_ready), .rd_valid (rd_valid),
        .mem_cs_n (mem_cs_n), .mem_ras_n (mem_ras_n), .mem_cas_n (mem_cas_n),
        .mem_we_n (mem_we_n), .mem_ba (mem_ba), .mem_addr (mem_addr)
    );

    // ------------------------------------------------------------ reference model
    logic [3:0]  q_code[$];
    logic [1:0]  q_ba[$];
    logic [12:0] q_addr[$];
    int          q_gap[$];
    string       q_tag[$];

    int    pwr_left = INIT_LIM + 1;
    int    gap_left = 0;
    string gap_tag  = "R4";
    int    since_ref = 0;
    bit    rd_h1 = 0, rd_h2 = 0;
    int    cyc = 0;
    int    last_ref = -1;

    task automatic push(input logic [3:0] c, input logic [1:0] b,
                        input logic [12:0] a, input int g, input string t);
        q_code.push_back(c); q_ba.push_back(b); q_addr.push_back(a);
        q_gap.push_back(g);  q_tag.push_back(t);
    endtask

    task automatic push_rw(input logic [27:0] a, input bit wr);
        logic [12:0] col;
        col = a[12:0];
        col[10] = 1'b1;
        push(C_ACT, a[27:26], a[25:13], TRCD - 1, wr ? "R6" : "R5");
        push(wr ? C_WR : C_RD, a[27:26], col, wr ? (TWR + TRP - 1) : 0, wr ? "R6" : "R5");
    endtask

    always @(negedge clk) begin
        logic [3:0]  e_code, o_code;
        logic [1:0]  e_ba;
        logic [12:0] e_addr;
        bit          e_rdy, is_ref, is_rd, in_pwr;
        string       tag;
        o_code = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
        if (!rst_n) begin
            checks++;
            if (o_code != C_NOP || usr_ready || rd_valid) begin
                errors++;
                $display("FAIL R1 reset lines=%b/%b rdy=%b/0 rdv=%b/0", o_code, C_NOP, usr_ready, rd_valid);
            end
        end else begin
            e_code = C_NOP; e_ba = '0; e_addr = '0; e_rdy = 0;
            is_ref = 0; is_rd = 0; tag = "R8";
            in_pwr = (pwr_left > 0);
            if (in_pwr) begin
                tag = "R1";
                pwr_left--;
                if (pwr_left == 0) begin
                    push(C_PRE,  2'd0, 13'h400, TRP - 1,  "R2");
                    push(C_MODE, 2'd1, 13'h002, TMRD - 1, "R2");
                    push(C_MODE, 2'd0, 13'h121, TMRD - 1, "R2");
                    push(C_PRE,  2'd0, 13'h400, TRP - 1,  "R2");
                    push(C_REF,  2'd0, 13'h000, TRFC - 1, "R2");
                    push(C_REF,  2'd0, 13'h000, TRFC - 1, "R2");
                    push(C_MODE, 2'd0, 13'h021, TMRD - 1, "R2");
                end
            end else if (gap_left > 0) begin
                tag = gap_tag;
                gap_left--;
            end else if (q_code.size() > 0) begin
                e_code = q_code.pop_front();
                e_ba   = q_ba.pop_front();
                e_addr = q_addr.pop_front();
                gap_left = q_gap.pop_front();
                tag    = q_tag.pop_front();
                gap_tag = (e_code == C_WR) ? "R6" : "R4";
                is_ref = (e_code == C_REF);
                is_rd  = (e_code == C_RD);
            end else begin
                e_rdy = (since_ref < RI - RW);
                if (!e_rdy) begin
                    tag = "R9";
                    push(C_REF, 2'd0, 13'h000, TRFC - 1, "R9");
                end else begin
                    case (usr_cmd)
                        2'b01: push_rw(usr_addr, 1'b0);
                        2'b10: push_rw(usr_addr, 1'b1);
                        2'b11: push(C_REF, 2'd0, 13'h000, TRFC - 1, "R7");
                        default: ;
                    endcase
                end
            end
            checks++;
            if (o_code != e_code || mem_ba != e_ba || mem_addr != e_addr || usr_ready != e_rdy) begin
                errors++;
                $display("FAIL %s cyc %0d lines=%b/%b ba=%0d/%0d addr=%h/%h rdy=%b/%b",
                         tag, cyc, o_code, e_code, mem_ba, e_ba, mem_addr, e_addr, usr_ready, e_rdy);
            end
            checks++;
            if (rd_valid != rd_h2) begin
                errors++;
                $display("FAIL R10 cyc %0d rd_valid=%b/%b", cyc, rd_valid, rd_h2);
            end
            if (o_code != C_NOP) begin
                checks++;
                if (!(o_code inside {C_MODE, C_ACT, C_PRE, C_RD, C_WR, C_REF})) begin
                    errors++;
                    $display("FAIL R3 cyc %0d code=%b/legal", cyc, o_code);
                end
            end
            if (o_code == C_REF) begin
                if (last_ref >= 0) begin
                    checks++;
                    if (cyc - last_ref > RI) begin
                        errors++;
                        $display("FAIL R9 refresh gap=%0d/<=%0d", cyc - last_ref, RI);
                    end
                end
                last_ref = cyc;
            end
            rd_h2 = rd_h1;
            rd_h1 = is_rd;
            since_ref = (in_pwr || is_ref) ? 0 : since_ref + 1;
            cyc++;
        end
    end

    // ------------------------------------------------------------ stimulus
    task automatic wait_ready();
        while (!usr_ready) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic issue(input logic [1:0] c, input logic [27:0] a);
        wait_ready();
        usr_cmd = c; usr_addr = a;
        @(posedge clk); #1;
        usr_cmd = 2'b00;
    endtask

    initial begin
        logic [27:0] lf;
        lf = 28'h5A3C_E17;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R5, R6, R7 single transactions
        issue(2'b01, {2'd2, 13'h1ABC, 13'h0123});
        issue(2'b10, {2'd1, 13'h0F0F, 13'h1FFF});
        issue(2'b11, 28'h0);
        issue(2'b01, {2'd3, 13'h1FFF, 13'h0000});
        // mixed pattern
        for (int k = 0; k < 12; k++) begin
            lf = {lf[26:0], lf[27] ^ lf[24]};
            issue(lf[0] ? 2'b10 : 2'b01, lf);
        end
        // R9: idle past the refresh due point
        repeat (820) @(posedge clk);
        #0;
        // R8: commands held while ready is low, through a refresh deadline
        usr_cmd = 2'b10;
        for (int k = 0; k < 900; k++) begin
            usr_addr = 28'(k * 28'h0013579) ^ 28'hA5A5A5A;
            usr_cmd  = (k % 3 == 0) ? 2'b01 : ((k % 7 == 0) ? 2'b11 : 2'b10);
            @(posedge clk); #1;
        end
        usr_cmd = 2'b00;
        issue(2'b01, {2'd0, 13'h0001, 13'h0402});
        issue(2'b01, {2'd1, 13'h0002, 13'h0004});
        repeat (20) @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R8 watchdog state=hung/expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule